// File: doc/BRIEF.md
# Trap Entry CSR Update Unit

This unit handles the state changes a processor hart makes when it takes a trap. When a trap strobe arrives, it decides whether the trap goes to the supervisor level or to the machine level. For an interrupt the decision uses a held interrupt-delegation mask, and for an exception it uses a held exception-delegation mask. The unit then records the faulting PC, the trap value, the guest-physical fault address and the transformed instruction in the register set of the chosen level. It also produces the redirect PC taken from that level's trap vector and updates the current privilege mode.

The delegation masks, both trap vectors and the current privilege mode are loaded through a small configuration port. The same port reads them back. The privilege write lets the surrounding core lower the mode after a trap return. Saving and restoring status-stack bits, virtualization state and software CSR access are the job of the surrounding core.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset the privilege mode is M (encoding 3), `redirect_valid` is low, and every recorded CSR output and every configuration register reads zero.
- R2: Configuration address 0 selects the interrupt-delegation mask, 1 the exception-delegation mask, 2 the supervisor vector, 3 the machine vector and 4 the privilege mode (low two bits). A write happens at the clock edge where `cfg_we` is high and `trap_valid` is low. If `trap_valid` is high at that edge, the write is dropped. `cfg_rdata` shows the addressed register combinationally.
- R3: A trap goes to supervisor level only when the current privilege is not M and bit `trap_cause` is set in the interrupt-delegation mask (when `trap_async` is 1) or in the exception-delegation mask (when `trap_async` is 0). In every other case it goes to machine level.
- R4: The cycle after `trap_valid` is sampled high, `redirect_valid` is high for one cycle. `redirect_pc` is then the chosen vector with bits [1:0] cleared, plus 4×cause only when the trap is asynchronous and the vector's bits [1:0] equal 01.
- R5: A supervisor-level trap loads `sepc` with `cur_pc` and loads `stval`, `htval` and `htinst`. It sets the privilege to S (encoding 1) and leaves the machine-level outputs unchanged.
- R6: A machine-level trap loads `mepc` with `cur_pc` and loads `mtval`, `mtval2` and `mtinst`. It sets the privilege to M and leaves the supervisor-level outputs unchanged.
- R7: For synchronous causes 0, 1, 4, 5, 6, 7, 12, 13, 15, 20, 21 and 23 the trap value is `bad_addr`. For any other cause, and for every interrupt, it is zero.
- R8: For synchronous causes 4, 5, 6, 7, 13, 15, 21 and 23 (the load and store/AMO faults) the transformed-instruction value is `xform_insn`. For fetch faults, other exceptions and interrupts it is zero.
- R9: For synchronous causes 20, 21 and 23 (the guest faults) the second address value written to `htval` or `mtval2` is `fault_gpa`. Otherwise it is zero.
- R10: A trap taken while the privilege is M stays at M, even when the cause's delegation bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_valid | input | 1 | Take a trap at this edge |
| trap_async | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause | input | CAUSE_W | Cause code |
| cur_pc | input | XLEN | PC of the trapping instruction |
| bad_addr | input | XLEN | Faulting virtual address |
| xform_insn | input | XLEN | Transformed instruction encoding |
| fault_gpa | input | XLEN | Guest-physical fault address |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | XLEN | Configuration write data |
| cfg_rdata | output | XLEN | Configuration read data |
| redirect_valid | output | 1 | One-cycle redirect strobe |
| redirect_pc | output | XLEN | Handler address |
| priv_o | output | 2 | Current privilege mode |
| sepc | output | XLEN | Supervisor exception PC |
| stval | output | XLEN | Supervisor trap value |
| htval | output | XLEN | Supervisor-path guest address |
| htinst | output | XLEN | Supervisor-path transformed instruction |
| mepc | output | XLEN | Machine exception PC |
| mtval | output | XLEN | Machine trap value |
| mtval2 | output | XLEN | Machine-path guest address |
| mtinst | output | XLEN | Machine-path transformed instruction |

## Verification
The case hardest to reach from the ports is a trap whose delegation bit is set but which still stays at machine level because the hart is already at M. The stimulus gets there by writing the privilege register before each table vector, so delegated causes are tried at U, S and M. The other hard case is a configuration write that arrives in the same cycle as a trap. The bench raises both strobes together and then reads the vector register back to show the write was dropped.

// File: rtl/trap_entry_pkg.sv
`timescale 1ns/1ps
package trap_entry_pkg;

    typedef enum logic [1:0] {
        PRIV_U = 2'd0,
        PRIV_S = 2'd1,
        PRIV_M = 2'd3
    } priv_e;

    localparam logic [2:0] CFG_IDELEG = 3'd0;
    localparam logic [2:0] CFG_EDELEG = 3'd1;
    localparam logic [2:0] CFG_STVEC  = 3'd2;
    localparam logic [2:0] CFG_MTVEC  = 3'd3;
    localparam logic [2:0] CFG_PRIV   = 3'd4;

    // cause classes as bit masks over exception codes 0..63
    localparam logic [63:0] ADDR_CAUSES  = 64'h0000_0000_00B0_B0F3;
    localparam logic [63:0] MEM_CAUSES   = 64'h0000_0000_00A0_A0F0;
    localparam logic [63:0] GUEST_CAUSES = 64'h0000_0000_00B0_0000;

    function automatic logic in_class(logic [63:0] mask, int unsigned code);
        return (code < 64) ? mask[code[5:0]] : 1'b0;
    endfunction

endpackage

// File: rtl/trap_route.sv
`timescale 1ns/1ps
module trap_route
    import trap_entry_pkg::*;
#(
    parameter int CAUSE_W = 6,
    parameter int DELEG_W = 1 << CAUSE_W
) (
    input  logic               is_async,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [1:0]         priv,
    input  logic [DELEG_W-1:0] ideleg,
    input  logic [DELEG_W-1:0] edeleg,
    output logic               to_super
);
    logic bit_set;

    always_comb begin
        bit_set  = is_async ? ideleg[cause] : edeleg[cause];
        to_super = bit_set && (priv != PRIV_M);
    end
endmodule

// File: rtl/trap_value_sel.sv
`timescale 1ns/1ps
module trap_value_sel
    import trap_entry_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int CAUSE_W = 6
) (
    input  logic               is_async,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [XLEN-1:0]    bad_addr,
    input  logic [XLEN-1:0]    xform_insn,
    input  logic [XLEN-1:0]    fault_gpa,
    output logic [XLEN-1:0]    tval,
    output logic [XLEN-1:0]    tinst,
    output logic [XLEN-1:0]    gval
);
    int unsigned code;
    logic        addr_hit;
    logic        mem_hit;
    logic        guest_hit;

    always_comb begin
        code      = int'(cause);
        addr_hit  = !is_async && in_class(ADDR_CAUSES, code);
        mem_hit   = !is_async && in_class(MEM_CAUSES, code);
        guest_hit = !is_async && in_class(GUEST_CAUSES, code);
        tval      = addr_hit  ? bad_addr   : '0;
        tinst     = mem_hit   ? xform_insn : '0;
        gval      = guest_hit ? fault_gpa  : '0;
    end
endmodule

// File: rtl/trap_vector_calc.sv
`timescale 1ns/1ps
module trap_vector_calc #(
    parameter int XLEN    = 64,
    parameter int CAUSE_W = 6
) (
    input  logic [XLEN-1:0]    tvec,
    input  logic               is_async,
    input  logic [CAUSE_W-1:0] cause,
    output logic [XLEN-1:0]    target_pc
);
    localparam logic [1:0] MODE_VECTORED = 2'b01;

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    always_comb begin
        base   = {tvec[XLEN-1:2], 2'b00};
        offset = (is_async && (tvec[1:0] == MODE_VECTORED))
                 ? (XLEN'(cause) << 2) : '0;
        target_pc = base + offset;
    end
endmodule

// File: rtl/trap_entry_unit.sv
`timescale 1ns/1ps
module trap_entry_unit
    import trap_entry_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int CAUSE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_valid,
    input  logic               trap_async,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic [XLEN-1:0]    bad_addr,
    input  logic [XLEN-1:0]    xform_insn,
    input  logic [XLEN-1:0]    fault_gpa,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_addr,
    input  logic [XLEN-1:0]    cfg_wdata,
    output logic [XLEN-1:0]    cfg_rdata,
    output logic               redirect_valid,
    output logic [XLEN-1:0]    redirect_pc,
    output logic [1:0]         priv_o,
    output logic [XLEN-1:0]    sepc,
    output logic [XLEN-1:0]    stval,
    output logic [XLEN-1:0]    htval,
    output logic [XLEN-1:0]    htinst,
    output logic [XLEN-1:0]    mepc,
    output logic [XLEN-1:0]    mtval,
    output logic [XLEN-1:0]    mtval2,
    output logic [XLEN-1:0]    mtinst
);
    localparam int DELEG_W = 1 << CAUSE_W;

    typedef struct packed {
        logic [DELEG_W-1:0] ideleg;
        logic [DELEG_W-1:0] edeleg;
        logic [XLEN-1:0]    stvec;
        logic [XLEN-1:0]    mtvec;
        logic [1:0]         priv;
        logic               rvalid;
        logic [XLEN-1:0]    rpc;
        logic [XLEN-1:0]    sepc;
        logic [XLEN-1:0]    stval;
        logic [XLEN-1:0]    htval;
        logic [XLEN-1:0]    htinst;
        logic [XLEN-1:0]    mepc;
        logic [XLEN-1:0]    mtval;
        logic [XLEN-1:0]    mtval2;
        logic [XLEN-1:0]    mtinst;
    } unit_state_t;

    unit_state_t st_d, st_q;

    logic            to_super;
    logic [XLEN-1:0] tval_w, tinst_w, gval_w;
    logic [XLEN-1:0] tvec_sel;
    logic [XLEN-1:0] target_pc;

    trap_route #(.CAUSE_W(CAUSE_W), .DELEG_W(DELEG_W)) u_route (
        .is_async (trap_async),
        .cause    (trap_cause),
        .priv     (st_q.priv),
        .ideleg   (st_q.ideleg),
        .edeleg   (st_q.edeleg),
        .to_super (to_super)
    );

    trap_value_sel #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_values (
        .is_async   (trap_async),
        .cause      (trap_cause),
        .bad_addr   (bad_addr),
        .xform_insn (xform_insn),
        .fault_gpa  (fault_gpa),
        .tval       (tval_w),
        .tinst      (tinst_w),
        .gval       (gval_w)
    );

    assign tvec_sel = to_super ? st_q.stvec : st_q.mtvec;

    trap_vector_calc #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_vector (
        .tvec      (tvec_sel),
        .is_async  (trap_async),
        .cause     (trap_cause),
        .target_pc (target_pc)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        if (trap_valid) begin
            st_d.rvalid = 1'b1;
            st_d.rpc    = target_pc;
            if (to_super) begin
                st_d.sepc   = cur_pc;
                st_d.stval  = tval_w;
                st_d.htval  = gval_w;
                st_d.htinst = tinst_w;
                st_d.priv   = PRIV_S;
            end else begin
                st_d.mepc   = cur_pc;
                st_d.mtval  = tval_w;
                st_d.mtval2 = gval_w;
                st_d.mtinst = tinst_w;
                st_d.priv   = PRIV_M;
            end
        end else if (cfg_we) begin
            case (cfg_addr)
                CFG_IDELEG: st_d.ideleg = cfg_wdata[DELEG_W-1:0];
                CFG_EDELEG: st_d.edeleg = cfg_wdata[DELEG_W-1:0];
                CFG_STVEC:  st_d.stvec  = cfg_wdata;
                CFG_MTVEC:  st_d.mtvec  = cfg_wdata;
                CFG_PRIV:   st_d.priv   = cfg_wdata[1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.priv <= PRIV_M;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (cfg_addr)
            CFG_IDELEG: cfg_rdata = XLEN'(st_q.ideleg);
            CFG_EDELEG: cfg_rdata = XLEN'(st_q.edeleg);
            CFG_STVEC:  cfg_rdata = st_q.stvec;
            CFG_MTVEC:  cfg_rdata = st_q.mtvec;
            CFG_PRIV:   cfg_rdata = XLEN'(st_q.priv);
            default:    cfg_rdata = '0;
        endcase
    end

    assign redirect_valid = st_q.rvalid;
    assign redirect_pc    = st_q.rpc;
    assign priv_o         = st_q.priv;
    assign sepc           = st_q.sepc;
    assign stval          = st_q.stval;
    assign htval          = st_q.htval;
    assign htinst         = st_q.htinst;
    assign mepc           = st_q.mepc;
    assign mtval          = st_q.mtval;
    assign mtval2         = st_q.mtval2;
    assign mtinst         = st_q.mtinst;

endmodule

// File: rtl/trap_entry_chk.sv
`timescale 1ns/1ps
module trap_entry_chk #(
    parameter int XLEN    = 64,
    parameter int CAUSE_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trap_valid,
    input logic            trap_async,
    input logic [XLEN-1:0] cur_pc,
    input logic            redirect_valid,
    input logic [XLEN-1:0] redirect_pc,
    input logic [1:0]      priv_o,
    input logic [XLEN-1:0] mepc,
    input logic [XLEN-1:0] mtinst
);
    // R4
    redirect_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> redirect_valid);

    // R4
    redirect_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |=> !redirect_valid);

    // R4
    redirect_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (redirect_pc[1:0] == 2'b00));

    // R10
    machine_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && priv_o == 2'd3) |=> (priv_o == 2'd3 && mepc == $past(cur_pc)));

    // R8
    irq_no_tinst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && trap_async && priv_o == 2'd3) |=> (mtinst == '0));

    // R5
    super_keeps_mepc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && priv_o == 2'd1) |-> $stable(mepc));
endmodule

bind trap_entry_unit trap_entry_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) i_trap_entry_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .trap_valid     (trap_valid),
    .trap_async     (trap_async),
    .cur_pc         (cur_pc),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .priv_o         (priv_o),
    .mepc           (mepc),
    .mtinst         (mtinst)
);

// File: tb/test_trap_entry_unit.sv
`timescale 1ns/1ps
module test_trap_entry_unit;
    localparam int XLEN    = 64;
    localparam int CAUSE_W = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trap_valid = 1'b0;
    logic              trap_async = 1'b0;
    logic [CAUSE_W-1:0] trap_cause = '0;
    logic [XLEN-1:0]   cur_pc = '0, bad_addr = '0, xform_insn = '0, fault_gpa = '0;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_addr = 3'd0;
    logic [XLEN-1:0]   cfg_wdata = '0;
    logic [XLEN-1:0]   cfg_rdata;
    logic              redirect_valid;
    logic [XLEN-1:0]   redirect_pc;
    logic [1:0]        priv_o;
    logic [XLEN-1:0]   sepc, stval, htval, htinst, mepc, mtval, mtval2, mtinst;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    trap_entry_unit #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) i_trap_entry_unit (.*);

    typedef struct packed {
        logic [1:0]  pv;
        logic        as;
        logic [5:0]  cs;
        logic        to_s;
        logic [63:0] pc;
        logic        tv;
        logic        ti;
        logic        gp;
    } vec_t;

    // stvec = 0x8000_1001 (vectored), mtvec = 0x4000_0003 (mode 3, direct)
    localparam vec_t VECS [12] = '{
        '{2'd0, 1'b0, 6'd13, 1'b1, 64'h8000_1000, 1'b1, 1'b1, 1'b0},
        '{2'd0, 1'b0, 6'd5,  1'b0, 64'h4000_0000, 1'b1, 1'b1, 1'b0},
        '{2'd1, 1'b1, 6'd5,  1'b1, 64'h8000_1014, 1'b0, 1'b0, 1'b0},
        '{2'd0, 1'b1, 6'd7,  1'b0, 64'h4000_0000, 1'b0, 1'b0, 1'b0},
        '{2'd3, 1'b0, 6'd13, 1'b0, 64'h4000_0000, 1'b1, 1'b1, 1'b0},
        '{2'd1, 1'b0, 6'd1,  1'b0, 64'h4000_0000, 1'b1, 1'b0, 1'b0},
        '{2'd0, 1'b0, 6'd0,  1'b1, 64'h8000_1000, 1'b1, 1'b0, 1'b0},
        '{2'd1, 1'b0, 6'd21, 1'b1, 64'h8000_1000, 1'b1, 1'b1, 1'b1},
        '{2'd0, 1'b0, 6'd2,  1'b0, 64'h4000_0000, 1'b0, 1'b0, 1'b0},
        '{2'd1, 1'b0, 6'd20, 1'b0, 64'h4000_0000, 1'b1, 1'b0, 1'b1},
        '{2'd0, 1'b0, 6'd6,  1'b1, 64'h8000_1000, 1'b1, 1'b1, 1'b0},
        '{2'd3, 1'b1, 6'd9,  1'b0, 64'h4000_0000, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(logic [2:0] a, logic [63:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic fire(logic as, logic [5:0] cs, logic [63:0] pc, logic [63:0] ba,
                        logic [63:0] xi, logic [63:0] gp);
        @(negedge clk);
        trap_valid = 1'b1; trap_async = as; trap_cause = cs;
        cur_pc = pc; bad_addr = ba; xform_insn = xi; fault_gpa = gp;
        @(negedge clk);
        trap_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [63:0] ba, xi, gp, pc, old_s, old_m;
        logic [63:0] edeleg_v;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "priv", 64'(priv_o), 64'd3);
        chk("R1", "redirect_valid", 64'(redirect_valid), 64'd0);
        chk("R1", "mepc", mepc, 64'd0);
        chk("R1", "sepc", sepc, 64'd0);
        cfg_addr = 3'd2; #1;
        chk("R1", "stvec readback", cfg_rdata, 64'd0);
        rst_n = 1'b1;

        edeleg_v = (64'd1 << 0) | (64'd1 << 4) | (64'd1 << 6) | (64'd1 << 13)
                 | (64'd1 << 15) | (64'd1 << 21) | (64'd1 << 23);
        cfg_write(3'd0, 64'h222);
        cfg_write(3'd1, edeleg_v);
        cfg_write(3'd2, 64'h8000_1001);
        cfg_write(3'd3, 64'h4000_0003);
        cfg_addr = 3'd1; #1;
        // R2: readback
        chk("R2", "edeleg readback", cfg_rdata, edeleg_v);
        cfg_addr = 3'd3; #1;
        chk("R2", "mtvec readback", cfg_rdata, 64'h4000_0003);

        foreach (VECS[i]) begin
            vec_t v;
            v  = VECS[i];
            pc = 64'h1000_0000 + 64'(i) * 64'h10;
            ba = 64'hBAD0_0000 + 64'(i);
            xi = 64'h0000_3000 + 64'(i);
            gp = 64'h6000_0000 + 64'(i);
            cfg_write(3'd4, 64'(v.pv));
            old_s = sepc; old_m = mepc;
            fire(v.as, v.cs, pc, ba, xi, gp);
            // R3 R4 R10: routing and redirect
            chk("R4", $sformatf("vec%0d redirect_valid", i), 64'(redirect_valid), 64'd1);
            chk("R4", $sformatf("vec%0d redirect_pc", i), redirect_pc, v.pc);
            chk("R3", $sformatf("vec%0d priv", i), 64'(priv_o), v.to_s ? 64'd1 : 64'd3);
            if (v.to_s) begin
                chk("R5", $sformatf("vec%0d sepc", i), sepc, pc);
                chk("R5", $sformatf("vec%0d mepc kept", i), mepc, old_m);
                chk("R7", $sformatf("vec%0d stval", i), stval, v.tv ? ba : 64'd0);
                chk("R8", $sformatf("vec%0d htinst", i), htinst, v.ti ? xi : 64'd0);
                chk("R9", $sformatf("vec%0d htval", i), htval, v.gp ? gp : 64'd0);
            end else begin
                chk("R6", $sformatf("vec%0d mepc", i), mepc, pc);
                chk("R6", $sformatf("vec%0d sepc kept", i), sepc, old_s);
                chk("R7", $sformatf("vec%0d mtval", i), mtval, v.tv ? ba : 64'd0);
                chk("R8", $sformatf("vec%0d mtinst", i), mtinst, v.ti ? xi : 64'd0);
                chk("R9", $sformatf("vec%0d mtval2", i), mtval2, v.gp ? gp : 64'd0);
            end
        end

        // R4: strobe lasts one cycle
        @(negedge clk);
        chk("R4", "redirect_valid drop", 64'(redirect_valid), 64'd0);

        // R4: vectored machine vector, interrupt adds 4*cause
        cfg_write(3'd3, 64'h4000_0001);
        cfg_write(3'd4, 64'd3);
        fire(1'b1, 6'd11, 64'h2000, 64'h0, 64'h0, 64'h0);
        chk("R4", "vectored irq pc", redirect_pc, 64'h4000_002C);
        // R4: synchronous trap with vectored mode uses base only
        fire(1'b0, 6'd2, 64'h2004, 64'h0, 64'h0, 64'h0);
        chk("R4", "vectored sync pc", redirect_pc, 64'h4000_0000);

        // R10: delegated cause at M stays M
        fire(1'b0, 6'd13, 64'h2008, 64'h77, 64'h88, 64'h0);
        chk("R10", "priv at M", 64'(priv_o), 64'd3);
        chk("R10", "mepc at M", mepc, 64'h2008);

        // R2: config write coinciding with a trap is dropped
        @(negedge clk);
        trap_valid = 1'b1; trap_async = 1'b0; trap_cause = 6'd2; cur_pc = 64'h3000;
        cfg_we = 1'b1; cfg_addr = 3'd2; cfg_wdata = 64'hDEAD_0000;
        @(negedge clk);
        trap_valid = 1'b0; cfg_we = 1'b0; #1;
        chk("R2", "stvec unchanged under trap", cfg_rdata, 64'h8000_1001);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule